// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Stack

This block keeps the active-lane mask of a wide SIMD processor while it runs nested divergent branches. Every lane walks through both the taken and the not-taken path. The mask held here decides which lanes are allowed to commit a result at each step.

At a divergent branch the sequencer issues a push command together with a per-lane predicate vector. The current mask is saved on an internal stack, and the then-path lanes become active. Between the two paths a complement command switches to the lanes of the else path. At the reconvergence point a pop command restores the mask that was saved.

The stack depth is a parameter. Misuse is reported through two sticky error flags: one for pushing onto a full stack and one for popping an empty stack.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, `active_mask` is all ones, `stack_empty` is 1, and both `overflow` and `underflow` are 0.
- R2: Push (`cmd` = 2'b01) with fewer than DEPTH saved entries stores the current mask on the stack and sets the mask to the current mask ANDed with `pred`.
- R3: Complement (`cmd` = 2'b10) sets the mask to the top saved mask ANDed with the inverse of the current mask. With an empty stack, the top is taken as all ones. The stack does not change.
- R4: Pop (`cmd` = 2'b11) on a non-empty stack restores the most recently saved mask and removes it. Nested pushes unwind in last-in, first-out order.
- R5: Push while DEPTH entries are saved sets `overflow`. The mask and the stack contents stay unchanged.
- R6: Pop on an empty stack sets `underflow` and leaves the mask unchanged.
- R7: `overflow` and `underflow` stay set until the next reset, whatever commands follow.
- R8: `cmd` = 2'b00 is idle: it has no effect for any `pred`. Every command takes effect at the next rising clock edge, and one command is taken per cycle.
- R9: `stack_empty` is 1 exactly when no mask is saved on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 00 idle, 01 push, 10 complement, 11 pop |
| pred | input | LANES | Per-lane branch predicate, used by push |
| active_mask | output | LANES | Lanes allowed to commit results |
| stack_empty | output | 1 | No saved mask on the stack |
| overflow | output | 1 | Sticky: a push found the stack full |
| underflow | output | 1 | Sticky: a pop found the stack empty |

## Verification
Each command changes `active_mask`, `stack_empty` and the flags on the first rising edge after it is presented. No result is due later than that. The bench applies `cmd` and `pred` on a falling edge and returns `cmd` to idle on the next falling edge. It compares every output at that same falling edge, half a period after the edge that registered the command. As a result, each check sees exactly one command's effect. The nested and full-depth scenarios then confirm that the saved masks come back in reverse order through later pops.

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] active_mask,
  output logic             stack_empty,
  output logic             overflow,
  output logic             underflow
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] OP_PUSH = 2'b01;
  localparam logic [1:0] OP_FLIP = 2'b10;
  localparam logic [1:0] OP_POP  = 2'b11;

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] saved_q [DEPTH];
  logic [PW-1:0]    sp_q;
  logic             ovf_q, unf_q;

  wire full  = (sp_q == PW'(DEPTH));
  wire empty = (sp_q == '0);
  wire [PW-1:0] sp_dec = sp_q - 1'b1;
  wire [AW-1:0] wr_idx = AW'(sp_q);
  wire [AW-1:0] top_idx = AW'(sp_dec);
  wire [LANES-1:0] top_mask = empty ? {LANES{1'b1}} : saved_q[top_idx];

  wire do_push = (cmd == OP_PUSH) && !full;
  wire do_pop  = (cmd == OP_POP) && !empty;
  wire do_flip = (cmd == OP_FLIP);

  always_ff @(posedge clk) begin
    if (do_push) saved_q[wr_idx] <= mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sp_q   <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (do_push) begin
        mask_q <= mask_q & pred;
        sp_q   <= sp_q + 1'b1;
      end else if (do_pop) begin
        mask_q <= top_mask;
        sp_q   <= sp_dec;
      end else if (do_flip) begin
        mask_q <= top_mask & ~mask_q;
      end
      if (cmd == OP_PUSH && full) ovf_q <= 1'b1;
      if (cmd == OP_POP && empty) unf_q <= 1'b1;
    end
  end

  assign active_mask = mask_q;
  assign stack_empty = empty;
  assign overflow    = ovf_q;
  assign underflow   = unf_q;
endmodule

// File: rtl/lane_mask_stack_props.sv
module lane_mask_stack_props #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic [LANES-1:0] pred,
  input logic [LANES-1:0] active_mask,
  input logic             stack_empty,
  input logic             overflow,
  input logic             underflow,
  input logic             full
);
  p_push_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01 && !full) |=> active_mask == ($past(active_mask) & $past(pred)));

  p_flip_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b10) |=> (active_mask & $past(active_mask)) == '0);

  p_pop_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11 && $past(cmd) == 2'b01 && !$past(full)) |=> active_mask == $past(active_mask, 2));

  p_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01 && full) |=> overflow && $stable(active_mask));

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11 && stack_empty) |=> underflow && $stable(active_mask));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b00) |=> $stable(active_mask) && $stable(stack_empty));

  p_push_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |=> !stack_empty);
endmodule

bind lane_mask_stack lane_mask_stack_props #(.LANES(LANES)) u_props (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .pred(pred),
  .active_mask(active_mask), .stack_empty(stack_empty),
  .overflow(overflow), .underflow(underflow), .full(full)
);

// File: tb/test_lane_mask_stack.sv
module test_lane_mask_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] active_mask;
  logic stack_empty, overflow, underflow;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_lane_mask_stack (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .pred(pred),
    .active_mask(active_mask), .stack_empty(stack_empty),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic check(string req, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] c, logic [LANES-1:0] p);
    @(negedge clk);
    cmd = c;
    pred = p;
    @(negedge clk);
    cmd = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 mask", active_mask, '1);
    check("R1 empty", LANES'(stack_empty), 1);
    check("R1 overflow", LANES'(overflow), 0);
    check("R1 underflow", LANES'(underflow), 0);
  endtask

  task automatic t_idle();
    issue(2'b00, 32'h1234_5678);
    check("R8 idle mask", active_mask, '1);
    check("R8 idle empty", LANES'(stack_empty), 1);
  endtask

  task automatic t_if_else();
    issue(2'b01, 32'h0000_FFFF);
    check("R2 push mask", active_mask, 32'h0000_FFFF);
    check("R9 not empty", LANES'(stack_empty), 0);
    issue(2'b10, '0);
    check("R3 complement", active_mask, 32'hFFFF_0000);
    issue(2'b11, '0);
    check("R4 pop mask", active_mask, '1);
    check("R9 empty after pop", LANES'(stack_empty), 1);
  endtask

  task automatic t_nested();
    issue(2'b01, 32'h00FF_00FF);
    check("R2 outer push", active_mask, 32'h00FF_00FF);
    issue(2'b01, 32'h0F0F_0F0F);
    check("R2 inner push", active_mask, 32'h000F_000F);
    issue(2'b10, '0);
    check("R3 inner complement", active_mask, 32'h00F0_00F0);
    issue(2'b11, '0);
    check("R4 inner pop", active_mask, 32'h00FF_00FF);
    issue(2'b10, '0);
    check("R3 outer complement", active_mask, 32'hFF00_FF00);
    issue(2'b11, '0);
    check("R4 outer pop", active_mask, '1);
  endtask

  task automatic t_flip_empty();
    issue(2'b10, '0);
    check("R3 complement empty", active_mask, '0);
    issue(2'b10, '0);
    check("R3 complement empty back", active_mask, '1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      issue(2'b01, ~(LANES'(1) << i));
      check("R2 fill push", active_mask, ~((LANES'(1) << (i + 1)) - 1));
    end
    check("R5 no overflow at depth", LANES'(overflow), 0);
    issue(2'b01, '0);
    check("R5 overflow flag", LANES'(overflow), 1);
    check("R5 mask held", active_mask, ~((LANES'(1) << DEPTH) - 1));
    for (int j = DEPTH - 1; j >= 0; j--) begin
      issue(2'b11, '0);
      check("R4 unwind", active_mask, ~((LANES'(1) << j) - 1));
    end
    check("R9 empty after unwind", LANES'(stack_empty), 1);
    check("R7 overflow sticky", LANES'(overflow), 1);
  endtask

  task automatic t_underflow();
    issue(2'b11, '0);
    check("R6 underflow flag", LANES'(underflow), 1);
    check("R6 mask held", active_mask, '1);
    issue(2'b01, 32'h0000_0001);
    check("R2 push after underflow", active_mask, 32'h0000_0001);
    check("R7 underflow sticky", LANES'(underflow), 1);
    issue(2'b11, '0);
    check("R4 pop after underflow", active_mask, '1);
    do_reset();
    check("R7 cleared by reset ovf", LANES'(overflow), 0);
    check("R7 cleared by reset unf", LANES'(underflow), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_if_else();
    t_nested();
    t_flip_empty();
    t_overflow();
    t_underflow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule